// File: doc/BRIEF.md
# Reference Clock Period and Frequency Monitor

This block watches one incoming reference clock from a fast master clock domain and decides whether it is fit to serve as a timing source. The reference passes through a two-flop synchroniser. Three measurements then run side by side on it. The first times every single period against a low and a high limit. The second counts master clocks across a short group of reference cycles to catch large, sudden frequency changes. The third counts reference edges over a long, fixed master-clock window and compares the total with the nominal count.

The nominal rate is configured as N times 8 kHz. The long window lasts `PFM_UNITS` periods of 8 kHz, each `CLK_PER_8K` master clocks long, so the expected edge count is N × `PFM_UNITS`. A bench can shrink the window to about a thousand clocks instead of the seconds used in service. Any single-period or short-window failure restarts the long window. The long check uses two tolerances, so a reference sitting near the limit does not make the flag toggle. An optional divide-by-four makes both frequency checks use every fourth reference edge.

Top module: `refclk_monitor`

## Requirements
- R1: The period check measures master clocks between consecutive synchronised rising edges. At each edge it sets `per_fail` to 1 if that count is below `cfg_per_lo` or above `cfg_per_hi`, and to 0 otherwise. The first edge after reset only starts the measurement.
- R2: If no edge arrives, `per_fail` goes to 1 once the running count passes `cfg_per_hi`, while the reference is still silent.
- R3: The coarse check counts master clocks over `cfg_win_cycles_m1`+1 reference periods. At the closing edge it sets `win_fail` to 1 if the count lies outside [`cfg_win_lo`, `cfg_win_hi`] and to 0 inside. `win_fail` also goes to 1 as soon as a window's count passes `cfg_win_hi`.
- R4: The precise check counts reference edges over `CLK_PER_8K`×`PFM_UNITS` master clocks. It compares the total with `cfg_mult`×`PFM_UNITS`, and updates `prec_fail` only at the end of a window.
- R5: At the end of a window, a passing `prec_fail` becomes 1 only when the deviation exceeds `cfg_rej_tol`. A failing one becomes 0 only when the deviation is at most `cfg_acc_tol`. Otherwise it keeps its value.
- R6: Any period or coarse failure event restarts the precise window with no verdict, so `prec_fail` cannot change while such events keep coming faster than one window.
- R7: With `cfg_div4`=1, the coarse and precise checks use every fourth reference edge and the expected precise count is divided by 4. The period check is unaffected.
- R8: While `rst` is high, `per_fail`=0, `win_fail`=0 and `prec_fail`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock |
| cfg_mult | input | 14 | N for a nominal rate of N×8 kHz |
| cfg_per_lo | input | 16 | Shortest acceptable period, master clocks |
| cfg_per_hi | input | 16 | Longest acceptable period, master clocks |
| cfg_win_lo | input | 20 | Lowest acceptable coarse-window count |
| cfg_win_hi | input | 20 | Highest acceptable coarse-window count |
| cfg_win_cycles_m1 | input | 8 | Reference periods per coarse window, minus one |
| cfg_div4 | input | 1 | Divide the reference by 4 for the frequency checks |
| cfg_acc_tol | input | 16 | Deviation at or below which a failing reference is accepted |
| cfg_rej_tol | input | 16 | Deviation above which a passing reference is rejected |
| per_fail | output | 1 | Single-period failure flag |
| win_fail | output | 1 | Coarse frequency failure flag |
| prec_fail | output | 1 | Precise frequency failure flag |

## Verification
A reference rise reaches the edge detector after the two synchroniser flops, and the period and coarse flags are registered one clock later. Both flags are therefore due three master clocks after the edge that closes a measurement. A missing-edge flag is due three clocks after the running count passes its limit. The bench samples these flags on falling clock edges, with several clocks of margin either side of those points. The precise flag only moves at a window boundary, so the bench waits more than three full windows after each change of frequency and reads it while the reference is steady.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int PER_W  = 16;
    localparam int WIN_W  = 20;
    localparam int CYC_W  = 8;
    localparam int MULT_W = 14;
    localparam int TOL_W  = 16;
    localparam int DEV_W  = 48;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [PER_W-1:0]  per_lo;
        logic [PER_W-1:0]  per_hi;
        logic [WIN_W-1:0]  win_lo;
        logic [WIN_W-1:0]  win_hi;
        logic [CYC_W-1:0]  win_cyc_m1;
        logic              div4;
        logic [TOL_W-1:0]  acc_tol;
        logic [TOL_W-1:0]  rej_tol;
    } refmon_cfg_t;

    typedef struct packed {
        logic per_fail;
        logic win_fail;
        logic prec_fail;
    } refmon_flags_t;

    function automatic logic [DEV_W-1:0] abs_gap(input logic [DEV_W-1:0] a,
                                                 input logic [DEV_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/refmon_edge.sv
module refmon_edge (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    input  logic div4,
    output logic rise,
    output logic freq_tick
);
    logic [2:0] sh;
    logic [1:0] quarter;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            quarter <= '0;
        end else begin
            sh <= {sh[1:0], ref_async};
            if (rise) quarter <= quarter + 2'd1;
        end
    end

    always_comb begin
        rise      = sh[1] & ~sh[2];
        freq_tick = div4 ? (rise && (quarter == 2'd3)) : rise;
    end
endmodule

// File: rtl/refmon_span.sv
// Counts master clocks across CYC_M1+1 tick intervals and judges the total
// against a low/high band; an over-long interval fails before it closes.
module refmon_span #(
    parameter int CNT_W = 16,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CYC_W-1:0] cyc_m1,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    output logic             fail,
    output logic             evt
);
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CYC_W-1:0] ecnt;
    logic             at_end;
    logic             bad_len;
    logic             overrun;

    always_comb begin
        cnt_inc = (&cnt) ? cnt : cnt + 1'b1;
        at_end  = tick && armed && (ecnt == cyc_m1);
        bad_len = (cnt < lim_lo) || (cnt > lim_hi);
        overrun = armed && (cnt > lim_hi);
        evt     = (at_end && bad_len) || overrun;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            ecnt  <= '0;
            fail  <= 1'b0;
        end else begin
            if (tick) begin
                armed <= 1'b1;
                if (!armed || at_end) begin
                    cnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
                    ecnt <= '0;
                end else begin
                    cnt  <= cnt_inc;
                    ecnt <= ecnt + 1'b1;
                end
            end else if (armed) begin
                cnt <= cnt_inc;
            end

            if (at_end)       fail <= bad_len;
            else if (overrun) fail <= 1'b1;
        end
    end
endmodule

// File: rtl/refmon_precise.sv
module refmon_precise
    import refmon_pkg::*;
#(
    parameter int WIN   = 1024,
    parameter int UNITS = 16,
    parameter int WC_W  = 10,
    parameter int EXP_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              restart,
    input  logic [MULT_W-1:0] mult,
    input  logic              div4,
    input  logic [TOL_W-1:0]  acc_tol,
    input  logic [TOL_W-1:0]  rej_tol,
    output logic              fail,
    output logic              win_end
);
    logic [WC_W-1:0]  wcnt;
    logic [EXP_W-1:0] ecount;
    logic [EXP_W-1:0] count_now;
    logic [EXP_W-1:0] expect_full;
    logic [EXP_W-1:0] expect_cnt;
    logic [DEV_W-1:0] dev;
    logic             too_far;
    logic             close_in;

    always_comb begin
        win_end     = (wcnt == WC_W'(WIN - 1)) && !restart;
        count_now   = (&ecount) ? ecount : ecount + EXP_W'(tick);
        expect_full = EXP_W'(mult) * EXP_W'(UNITS);
        expect_cnt  = div4 ? (expect_full >> 2) : expect_full;
        dev         = abs_gap(DEV_W'(count_now), DEV_W'(expect_cnt));
        too_far     = dev >  DEV_W'(rej_tol);
        close_in    = dev <= DEV_W'(acc_tol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            ecount <= '0;
            fail   <= 1'b1;
        end else begin
            if (restart || win_end) begin
                wcnt   <= '0;
                ecount <= '0;
            end else begin
                wcnt   <= wcnt + 1'b1;
                ecount <= count_now;
            end
            if (win_end) fail <= fail ? !close_in : too_far;
        end
    end
endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor
    import refmon_pkg::*;
#(
    parameter int CLK_PER_8K = 2500,
    parameter int PFM_UNITS  = 80000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [PER_W-1:0]  cfg_per_lo,
    input  logic [PER_W-1:0]  cfg_per_hi,
    input  logic [WIN_W-1:0]  cfg_win_lo,
    input  logic [WIN_W-1:0]  cfg_win_hi,
    input  logic [CYC_W-1:0]  cfg_win_cycles_m1,
    input  logic              cfg_div4,
    input  logic [TOL_W-1:0]  cfg_acc_tol,
    input  logic [TOL_W-1:0]  cfg_rej_tol,
    output logic              per_fail,
    output logic              win_fail,
    output logic              prec_fail
);
    localparam int PREC_WIN = CLK_PER_8K * PFM_UNITS;
    localparam int WC_W     = $clog2(PREC_WIN);
    localparam int EXP_W    = $clog2(((1 << MULT_W) - 1) * PFM_UNITS + 1) + 1;

    refmon_cfg_t   cfg;
    refmon_flags_t flags;
    logic          ref_rise;
    logic          freq_tick;
    logic          per_evt;
    logic          win_evt;
    logic          prec_end;
    logic          restart;

    always_comb begin
        cfg.mult       = cfg_mult;
        cfg.per_lo     = cfg_per_lo;
        cfg.per_hi     = cfg_per_hi;
        cfg.win_lo     = cfg_win_lo;
        cfg.win_hi     = cfg_win_hi;
        cfg.win_cyc_m1 = cfg_win_cycles_m1;
        cfg.div4       = cfg_div4;
        cfg.acc_tol    = cfg_acc_tol;
        cfg.rej_tol    = cfg_rej_tol;
        restart        = per_evt || win_evt;
    end

    refmon_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .ref_async (ref_in),
        .div4      (cfg.div4),
        .rise      (ref_rise),
        .freq_tick (freq_tick)
    );

    refmon_span #(.CNT_W(PER_W), .CYC_W(CYC_W)) u_period (
        .clk    (clk),
        .rst    (rst),
        .tick   (ref_rise),
        .cyc_m1 ('0),
        .lim_lo (cfg.per_lo),
        .lim_hi (cfg.per_hi),
        .fail   (flags.per_fail),
        .evt    (per_evt)
    );

    refmon_span #(.CNT_W(WIN_W), .CYC_W(CYC_W)) u_coarse (
        .clk    (clk),
        .rst    (rst),
        .tick   (freq_tick),
        .cyc_m1 (cfg.win_cyc_m1),
        .lim_lo (cfg.win_lo),
        .lim_hi (cfg.win_hi),
        .fail   (flags.win_fail),
        .evt    (win_evt)
    );

    refmon_precise #(
        .WIN   (PREC_WIN),
        .UNITS (PFM_UNITS),
        .WC_W  (WC_W),
        .EXP_W (EXP_W)
    ) u_precise (
        .clk     (clk),
        .rst     (rst),
        .tick    (freq_tick),
        .restart (restart),
        .mult    (cfg.mult),
        .div4    (cfg.div4),
        .acc_tol (cfg.acc_tol),
        .rej_tol (cfg.rej_tol),
        .fail    (flags.prec_fail),
        .win_end (prec_end)
    );

    always_comb begin
        per_fail  = flags.per_fail;
        win_fail  = flags.win_fail;
        prec_fail = flags.prec_fail;
    end
endmodule

// File: rtl/refmon_checker.sv
module refmon_checker (
    input logic clk,
    input logic rst,
    input logic ref_rise,
    input logic freq_tick,
    input logic per_evt,
    input logic win_evt,
    input logic prec_end,
    input logic per_fail,
    input logic win_fail,
    input logic prec_fail
);
    p_per_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !ref_rise |=> !$fell(per_fail));

    p_per_evt_r2: assert property (@(posedge clk) disable iff (rst)
        per_evt |=> per_fail);

    p_win_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !freq_tick |=> !$fell(win_fail));

    p_prec_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !prec_end |=> $stable(prec_fail));

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (per_evt || win_evt) |=> $stable(prec_fail));

    p_tick_subset_r7: assert property (@(posedge clk) disable iff (rst)
        freq_tick |-> ref_rise);
endmodule

bind refclk_monitor refmon_checker u_refmon_checker (
    .clk       (clk),
    .rst       (rst),
    .ref_rise  (ref_rise),
    .freq_tick (freq_tick),
    .per_evt   (per_evt),
    .win_evt   (win_evt),
    .prec_end  (prec_end),
    .per_fail  (per_fail),
    .win_fail  (win_fail),
    .prec_fail (prec_fail)
);

// File: tb/test_refclk_monitor.sv
`timescale 1ns/1ps
module test_refclk_monitor;
    import refmon_pkg::*;

    localparam int CP8K  = 64;
    localparam int UNITS = 16;
    localparam int WIN   = CP8K * UNITS;
    localparam int MULT  = 8;
    localparam int SETTLE = 3500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic ref_gen  = 1'b0;
    logic hold_low = 1'b0;
    logic pulse_hi = 1'b0;
    int   per_ns   = 80;
    logic ref_in;
    assign ref_in = (ref_gen & ~hold_low) | pulse_hi;

    logic [MULT_W-1:0] cfg_mult = 14'(MULT);
    logic [PER_W-1:0]  cfg_per_lo = 16'd6;
    logic [PER_W-1:0]  cfg_per_hi = 16'd11;
    logic [WIN_W-1:0]  cfg_win_lo = 20'd56;
    logic [WIN_W-1:0]  cfg_win_hi = 20'd74;
    logic [CYC_W-1:0]  cfg_win_cycles_m1 = 8'd7;
    logic              cfg_div4 = 1'b0;
    logic [TOL_W-1:0]  cfg_acc_tol = 16'd4;
    logic [TOL_W-1:0]  cfg_rej_tol = 16'd8;
    logic per_fail, win_fail, prec_fail;

    refclk_monitor #(.CLK_PER_8K(CP8K), .PFM_UNITS(UNITS)) i_refclk_monitor (
        .clk               (clk),
        .rst               (rst),
        .ref_in            (ref_in),
        .cfg_mult          (cfg_mult),
        .cfg_per_lo        (cfg_per_lo),
        .cfg_per_hi        (cfg_per_hi),
        .cfg_win_lo        (cfg_win_lo),
        .cfg_win_hi        (cfg_win_hi),
        .cfg_win_cycles_m1 (cfg_win_cycles_m1),
        .cfg_div4          (cfg_div4),
        .cfg_acc_tol       (cfg_acc_tol),
        .cfg_rej_tol       (cfg_rej_tol),
        .per_fail          (per_fail),
        .win_fail          (win_fail),
        .prec_fail         (prec_fail)
    );

    initial begin
        forever begin
            ref_gen = 1'b1;
            #(per_ns / 2);
            ref_gen = 1'b0;
            #(per_ns - per_ns / 2);
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(input string req, input int e_per, input int e_win, input int e_prec);
        check(req, "per_fail", int'(per_fail), e_per);
        check(req, "win_fail", int'(win_fail), e_win);
        check(req, "prec_fail", int'(prec_fail), e_prec);
    endtask

    // Expected precise verdict from edge count over one window (R4, R5)
    function automatic int prec_expect(input int per, input int prev);
        int cnt;
        int dev;
        cnt = (WIN * 10) / per;
        dev = cnt - MULT * UNITS;
        if (dev < 0) dev = -dev;
        if (dev > 8)  return 1;
        if (dev <= 4) return 0;
        return prev;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
    end

    initial begin
        int prev;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);

        // R8: reset state
        wait_clk(10);
        check_flags("R8", 0, 0, 1);
        rst = 1'b0;
        wait_clk(3);
        check_flags("R8", 0, 0, 1);

        // R1 R3 R4: nominal reference passes everything
        wait_clk(SETTLE);
        check_flags("R1 R3 R4 nominal", 0, 0, prec_expect(80, 1));

        // R5: deviation inside the hysteresis band keeps pass
        per_ns = 84;
        wait_clk(SETTLE);
        check_flags("R5 hold pass", 0, 0, prec_expect(84, 0));

        // R4: far-off frequency fails the precise check only
        per_ns = 90;
        wait_clk(SETTLE);
        check_flags("R4 reject", 0, 0, prec_expect(90, 0));

        // R5: same band keeps fail
        per_ns = 84;
        wait_clk(SETTLE);
        check_flags("R5 hold fail", 0, 0, prec_expect(84, 1));

        per_ns = 80;
        wait_clk(SETTLE);
        check_flags("R5 accept", 0, 0, 0);

        // R1: an extra pulse makes short periods
        @(posedge ref_gen);
        #50 pulse_hi = 1'b1;
        #15 pulse_hi = 1'b0;
        @(posedge ref_gen);
        wait_clk(5);
        check("R1", "per_fail after short period", int'(per_fail), 1);
        wait_clk(40);
        check("R1", "per_fail after recovery", int'(per_fail), 0);

        // R2: missing edge flagged while reference stays silent
        @(negedge ref_gen);
        hold_low = 1'b1;
        wait_clk(5);
        check("R2", "per_fail before limit", int'(per_fail), 0);
        wait_clk(10);
        check("R2", "per_fail on missing edge", int'(per_fail), 1);
        wait_clk(80);
        check("R3", "win_fail on stalled window", int'(win_fail), 1);
        hold_low = 1'b0;
        wait_clk(SETTLE);
        check_flags("R2 recovery", 0, 0, 0);

        // R3: coarse window too long, then too short
        per_ns = 100;
        wait_clk(2000);
        check("R3", "win_fail slow", int'(win_fail), 1);
        check("R3", "per_fail slow", int'(per_fail), 0);
        per_ns = 68;
        wait_clk(2000);
        check("R3", "win_fail fast", int'(win_fail), 1);
        check("R3", "per_fail fast", int'(per_fail), 0);
        per_ns = 80;
        wait_clk(SETTLE);
        check_flags("R3 recovery", 0, 0, 0);

        // R6: failure events keep restarting the precise window
        per_ns = 90;
        for (int i = 0; i < 10; i++) begin
            wait_clk(350);
            @(negedge ref_gen);
            hold_low = 1'b1;
            #200 hold_low = 1'b0;
        end
        wait_clk(2);
        check("R6", "prec_fail frozen by restarts", int'(prec_fail), 0);
        wait_clk(SETTLE);
        check("R6", "prec_fail once restarts stop", int'(prec_fail), 1);

        // R7: divide by four scales the frequency checks
        per_ns = 80;
        cfg_div4 = 1'b1;
        cfg_win_lo = 20'd240;
        cfg_win_hi = 20'd300;
        wait_clk(SETTLE);
        check_flags("R7 divided", 0, 0, 0);
        cfg_div4 = 1'b0;
        wait_clk(500);
        check("R7", "win_fail undivided with divided limits", int'(win_fail), 1);
        check("R7", "per_fail unaffected", int'(per_fail), 0);
        cfg_win_lo = 20'd56;
        cfg_win_hi = 20'd74;
        wait_clk(SETTLE);
        check_flags("R7 restore", 0, 0, 0);

        // R4 R5: random good / bad frequencies
        prev = 0;
        for (int t = 0; t < 6; t++) begin
            int exp_p;
            if (($urandom % 2) == 0) per_ns = 78 + int'($urandom % 5);
            else                     per_ns = 87 + int'($urandom % 4);
            exp_p = prec_expect(per_ns, prev);
            wait_clk(SETTLE);
            check_flags($sformatf("R4 R5 random period %0d", per_ns), 0, 0, exp_p);
            prev = exp_p;
        end

        finish_run();
    end
endmodule